// File: doc/BRIEF.md
# 4:2:2 Pixel Byte Stream Splitter

This block sits at the front of a video encoder. It takes an 8-bit byte stream that carries interleaved luma and chroma samples in 4:2:2 order. The stream runs on a 27 MHz pixel clock, which is twice the luma rate and four times the rate of each chroma component. The block separates the stream into one luma sample per pixel and one Cb/Cr pair for every two pixels. The pair is co-sited with the even pixel, and each output stream has its own valid strobe.

The block locks onto each line when the active-low horizontal sync falls, so it realigns on every line with no other reset. Two static controls set the byte order. One exchanges the two chroma slots. The other puts luma in the first slot of every byte pair. Each sample is forced into its legal code range. Chroma leaves the block as a signed value centred on zero. A sleep input clears the block synchronously. After sleep, the block stays quiet until it sees the next sync fall.

Top module: `pix422_splitter`

## Requirements
- R1: While `rst_n` is low, `y_valid` and `c_valid` are low and `y_out`, `cb_out` and `cr_out` are zero. In the cycle after an edge that samples `sleep` high, the same holds, and the block sends no strobes until a new sync fall is seen.
- R2: A sync fall is an edge that samples `hsync_n` low when the previous edge sampled it high. The byte sampled at that edge becomes slot 0 of a new group, whatever slot the block had reached. The slots then run 0,1,2,3 and repeat.
- R3: With `luma_first`=0 and `swap_cbcr`=0 the slots carry Cb, Y(even), Cr, Y(odd).
- R4: With `swap_cbcr`=1 the two chroma slots exchange: slot 0 carries Cr and the second chroma slot carries Cb.
- R5: With `luma_first`=1 the slots carry Y(even), first chroma, Y(odd), second chroma. This combines with `swap_cbcr`.
- R6: Luma inputs 0..15 are output as 16, inputs 236..255 are output as 235, and 16..235 pass unchanged.
- R7: Chroma inputs are limited to 16..240 (0..15 become 16, 241..255 become 240). The limited code minus 128 is then output as an 8-bit two's-complement value.
- R8: If a luma byte, or the byte that completes a chroma pair, is sampled at edge n, its strobe is high and its value is present in the cycle after edge n+1, for that one cycle only.
- R9: `y_valid` pulses once per luma byte. `c_valid` pulses once per four-byte group. The two are never high in the same cycle.
- R10: After reset, no strobe is produced until the first sync fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Synchronous clear; holds the block idle |
| hsync_n | input | 1 | Active-low horizontal sync |
| swap_cbcr | input | 1 | 1: Cr occupies the first chroma slot |
| luma_first | input | 1 | 1: luma occupies the first slot of each byte pair |
| pix_in | input | 8 | Multiplexed YCbCr byte |
| y_out | output | 8 | Range-limited luma code |
| y_valid | output | 1 | Luma sample strobe |
| cb_out | output | 8 | Signed Cb, limited code minus 128 |
| cr_out | output | 8 | Signed Cr, limited code minus 128 |
| c_valid | output | 1 | Chroma pair strobe |

## Verification
Some properties are checked on every cycle. Output codes always stay inside their legal ranges. The two strobes never coincide. Each slot hit reaches its strobe one register later. Sleep silences the outputs, and nothing is emitted before the block is armed. A sync fall restarts the slot count at one. Only the bench's directed scenarios show which byte lands in which output under each of the four slot orders. The same holds for the exact saturation values at the range edges, the realignment from a part-finished group, and the two-edge latency measured against bytes driven at the pins.

// File: rtl/pix422_pkg.sv
package pix422_pkg;
    localparam int PIX_W  = 8;
    localparam int SLOTS  = 4;
    localparam int PH_W   = $clog2(SLOTS);
    localparam int Y_LO   = 16;
    localparam int Y_HI   = 235;
    localparam int C_LO   = 16;
    localparam int C_HI   = 240;
    localparam int C_ZERO = 128;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        logic            hs_prev;
        logic            armed;
        logic [PH_W-1:0] phase;
    } trk_t;

    typedef struct packed {
        pix_t c_hold;
        pix_t y_raw;
        pix_t cb_raw;
        pix_t cr_raw;
        logic y_hit;
        logic c_hit;
    } route_t;

    typedef struct packed {
        pix_t y;
        pix_t cb;
        pix_t cr;
        logic yv;
        logic cv;
    } outreg_t;
endpackage

// File: rtl/pix_range_limit.sv
module pix_range_limit #(
    parameter int W    = 8,
    parameter int LO   = 16,
    parameter int HI   = 235,
    parameter int ZERO = 0
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] lim
);
    logic [W-1:0] sat;

    always_comb begin
        if (raw < W'(LO)) begin
            sat = W'(LO);
        end else if (raw > W'(HI)) begin
            sat = W'(HI);
        end else begin
            sat = raw;
        end
        // subtracting the zero code wraps into two's complement
        lim = sat - W'(ZERO);
    end
endmodule

// File: rtl/pix_phase_track.sv
module pix_phase_track
    import pix422_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep,
    input  logic            hsync_n,
    output logic [PH_W-1:0] phase,
    output logic            active
);
    trk_t st_d, st_q;
    logic fall;

    always_comb begin
        fall   = st_q.hs_prev & ~hsync_n;
        phase  = fall ? '0 : st_q.phase;
        active = st_q.armed | fall;

        st_d         = st_q;
        st_d.hs_prev = hsync_n;
        st_d.armed   = active;
        if (active) begin
            st_d.phase = phase + 1'b1;
        end
        if (sleep) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // a sync fall consumes slot 0, so the next slot must be 1
    assert_line_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !sleep) |=> (st_q.phase == PH_W'(1)));

    // slot counter does not move while the block is unarmed
    assert_idle_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active) |=> (st_q.phase == '0));
endmodule

// File: rtl/pix_byte_router.sv
module pix_byte_router
    import pix422_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep,
    input  logic            active,
    input  logic [PH_W-1:0] phase,
    input  logic            swap_cbcr,
    input  logic            luma_first,
    input  pix_t            pix_in,
    output pix_t            y_raw,
    output logic            y_hit,
    output pix_t            cb_raw,
    output pix_t            cr_raw,
    output logic            c_hit
);
    route_t st_d, st_q;
    logic   y_slot, c1_slot, c2_slot;

    always_comb begin
        y_slot  = active & (phase[0] ^ luma_first);
        c1_slot = active & (phase == {1'b0, luma_first});
        c2_slot = active & (phase == {1'b1, luma_first});

        st_d       = st_q;
        st_d.y_hit = y_slot;
        st_d.c_hit = c2_slot;
        if (y_slot) begin
            st_d.y_raw = pix_in;
        end
        if (c1_slot) begin
            st_d.c_hold = pix_in;
        end
        if (c2_slot) begin
            st_d.cb_raw = swap_cbcr ? pix_in      : st_q.c_hold;
            st_d.cr_raw = swap_cbcr ? st_q.c_hold : pix_in;
        end
        if (sleep) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_raw  = st_q.y_raw;
    assign y_hit  = st_q.y_hit;
    assign cb_raw = st_q.cb_raw;
    assign cr_raw = st_q.cr_raw;
    assign c_hit  = st_q.c_hit;

    assert_role_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.y_hit && st_q.c_hit));

    assert_quiet_unarmed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active) |=> (!st_q.y_hit && !st_q.c_hit));
endmodule

// File: rtl/pix_out_stage.sv
module pix_out_stage
    import pix422_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  pix_t y_raw,
    input  logic y_hit,
    input  pix_t cb_raw,
    input  pix_t cr_raw,
    input  logic c_hit,
    output pix_t y_out,
    output logic y_valid,
    output pix_t cb_out,
    output pix_t cr_out,
    output logic c_valid
);
    localparam int NCH = 2;

    outreg_t st_d, st_q;
    pix_t    y_lim;
    pix_t    c_raw [NCH];
    pix_t    c_lim [NCH];

    assign c_raw[0] = cb_raw;
    assign c_raw[1] = cr_raw;

    pix_range_limit #(.W(PIX_W), .LO(Y_LO), .HI(Y_HI), .ZERO(0)) u_luma_lim (
        .raw(y_raw),
        .lim(y_lim)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chroma_lim
        pix_range_limit #(.W(PIX_W), .LO(C_LO), .HI(C_HI), .ZERO(C_ZERO)) u_lim (
            .raw(c_raw[ch]),
            .lim(c_lim[ch])
        );
    end

    always_comb begin
        st_d    = st_q;
        st_d.yv = y_hit;
        st_d.cv = c_hit;
        if (y_hit) begin
            st_d.y = y_lim;
        end
        if (c_hit) begin
            st_d.cb = c_lim[0];
            st_d.cr = c_lim[1];
        end
        if (sleep) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_out   = st_q.y;
    assign y_valid = st_q.yv;
    assign cb_out  = st_q.cb;
    assign cr_out  = st_q.cr;
    assign c_valid = st_q.cv;

    assert_luma_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> (y_out >= PIX_W'(Y_LO) && y_out <= PIX_W'(Y_HI)));

    assert_chroma_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        c_valid |-> ($signed(cb_out) >= -(C_ZERO - C_LO) && $signed(cb_out) <= (C_HI - C_ZERO)
                  && $signed(cr_out) >= -(C_ZERO - C_LO) && $signed(cr_out) <= (C_HI - C_ZERO)));

    assert_luma_latency_R8: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        y_hit |=> y_valid);

    assert_chroma_latency_R8: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        c_hit |=> c_valid);

    assert_sleep_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (!y_valid && !c_valid));
endmodule

// File: rtl/pix422_splitter.sv
module pix422_splitter
    import pix422_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep,
    input  logic                    hsync_n,
    input  logic                    swap_cbcr,
    input  logic                    luma_first,
    input  logic [PIX_W-1:0]        pix_in,
    output logic [PIX_W-1:0]        y_out,
    output logic                    y_valid,
    output logic signed [PIX_W-1:0] cb_out,
    output logic signed [PIX_W-1:0] cr_out,
    output logic                    c_valid
);
    logic [PH_W-1:0] phase;
    logic            active;
    pix_t            y_raw, cb_raw, cr_raw;
    logic            y_hit, c_hit;
    pix_t            cb_u, cr_u;

    pix_phase_track u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep  (sleep),
        .hsync_n(hsync_n),
        .phase  (phase),
        .active (active)
    );

    pix_byte_router u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .active    (active),
        .phase     (phase),
        .swap_cbcr (swap_cbcr),
        .luma_first(luma_first),
        .pix_in    (pix_in),
        .y_raw     (y_raw),
        .y_hit     (y_hit),
        .cb_raw    (cb_raw),
        .cr_raw    (cr_raw),
        .c_hit     (c_hit)
    );

    pix_out_stage u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep  (sleep),
        .y_raw  (y_raw),
        .y_hit  (y_hit),
        .cb_raw (cb_raw),
        .cr_raw (cr_raw),
        .c_hit  (c_hit),
        .y_out  (y_out),
        .y_valid(y_valid),
        .cb_out (cb_u),
        .cr_out (cr_u),
        .c_valid(c_valid)
    );

    assign cb_out = $signed(cb_u);
    assign cr_out = $signed(cr_u);
endmodule

// File: tb/pix422_splitter_test.sv
module pix422_splitter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep = 1'b0;
    logic       hsync_n = 1'b1;
    logic       swap_cbcr = 1'b0;
    logic       luma_first = 1'b0;
    logic [7:0] pix_in = 8'h00;
    logic [7:0] y_out;
    logic       y_valid;
    logic signed [7:0] cb_out, cr_out;
    logic       c_valid;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    bit    p_yv = 0, p_cv = 0;
    int    p_y = 0, p_cb = 0, p_cr = 0;
    string p_tag = "R1";

    always #2.5 clk = ~clk;

    pix422_splitter uut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .hsync_n(hsync_n),
        .swap_cbcr(swap_cbcr), .luma_first(luma_first), .pix_in(pix_in),
        .y_out(y_out), .y_valid(y_valid), .cb_out(cb_out), .cr_out(cr_out),
        .c_valid(c_valid)
    );

    function automatic int ylim(input int v);
        if (v < 16) return 16;
        if (v > 235) return 235;
        return v;
    endfunction

    function automatic int clim(input int v);
        int s;
        s = (v < 16) ? 16 : ((v > 240) ? 240 : v);
        return s - 128;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one byte per call; outputs checked against the byte sent one call earlier (R8)
    task automatic step(input bit hs, input bit sl, input int b,
                        input bit eyv, input int ey, input bit ecv,
                        input int ecb, input int ecr, input string tag);
        hsync_n = hs;
        sleep   = sl;
        pix_in  = 8'(b);
        @(posedge clk);
        @(negedge clk);
        if (sl) begin
            p_yv = 0;
            p_cv = 0;
            p_tag = "R1";
        end
        chk(y_valid == p_yv, {"R8 ", p_tag}, "y_valid", int'(y_valid), int'(p_yv));
        chk(c_valid == p_cv, {"R9 ", p_tag}, "c_valid", int'(c_valid), int'(p_cv));
        if (p_yv) chk(int'(y_out) == p_y, p_tag, "y_out", int'(y_out), p_y);
        if (p_cv) begin
            chk(int'(cb_out) == p_cb, p_tag, "cb_out", int'(cb_out), p_cb);
            chk(int'(cr_out) == p_cr, p_tag, "cr_out", int'(cr_out), p_cr);
        end
        if (sl) begin
            p_yv = 0;
            p_cv = 0;
        end else begin
            p_yv = eyv; p_y = ey; p_cv = ecv; p_cb = ecb; p_cr = ecr;
        end
        p_tag = tag;
        sleep = 1'b0;
    endtask

    task automatic send_quad(input bit hs, input bit lf, input bit sw,
                             input int cbv, input int y0, input int crv, input int y1,
                             input bit armed, input string tag);
        int c1, c2;
        luma_first = lf;
        swap_cbcr  = sw;
        c1 = sw ? crv : cbv;
        c2 = sw ? cbv : crv;
        if (!lf) begin
            step(hs, 0, c1, 0, 0, 0, 0, 0, tag);
            step(hs, 0, y0, armed, ylim(y0), 0, 0, 0, tag);
            step(hs, 0, c2, 0, 0, armed, clim(cbv), clim(crv), tag);
            step(hs, 0, y1, armed, ylim(y1), 0, 0, 0, tag);
        end else begin
            step(hs, 0, y0, armed, ylim(y0), 0, 0, 0, tag);
            step(hs, 0, c1, 0, 0, 0, 0, 0, tag);
            step(hs, 0, y1, armed, ylim(y1), 0, 0, 0, tag);
            step(hs, 0, c2, 0, 0, armed, clim(cbv), clim(crv), tag);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!y_valid && !c_valid, "R1", "strobes in reset", int'({y_valid, c_valid}), 0);
        chk(y_out == 0 && cb_out == 0 && cr_out == 0, "R1", "data in reset",
            int'(y_out) + int'(cb_out) + int'(cr_out), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_presync;
        for (int i = 0; i < 3; i++) begin
            send_quad(1, 0, 0, 60 + i, 70, 80, 90, 0, "R10");
        end
    endtask

    task automatic t_default;
        send_quad(0, 0, 0, 90, 100, 160, 110, 1, "R3");
        send_quad(0, 0, 0, 200, 50, 30, 180, 1, "R3");
        send_quad(1, 0, 0, 128, 16, 128, 16, 1, "R3");
    endtask

    task automatic t_swap;
        send_quad(0, 0, 1, 100, 120, 170, 130, 1, "R4");
        send_quad(0, 0, 1, 40, 60, 220, 90, 1, "R4");
        send_quad(1, 0, 1, 128, 16, 128, 16, 1, "R4");
    endtask

    task automatic t_luma_first;
        send_quad(0, 1, 0, 70, 140, 190, 150, 1, "R5");
        send_quad(1, 1, 0, 128, 16, 128, 16, 1, "R5");
        send_quad(0, 1, 1, 110, 45, 210, 55, 1, "R5");
        send_quad(1, 1, 1, 128, 16, 128, 16, 1, "R5");
    endtask

    task automatic t_clamp;
        send_quad(0, 0, 0, 0, 15, 255, 236, 1, "R6/R7");
        send_quad(0, 0, 0, 15, 16, 241, 255, 1, "R6/R7");
        send_quad(0, 0, 0, 240, 235, 16, 0, 1, "R6/R7");
        send_quad(0, 0, 0, 17, 234, 239, 1, 1, "R6/R7");
    endtask

    task automatic t_realign;
        // half a group, then a fresh sync fall restarts at slot 0
        step(1, 0, 50, 0, 0, 0, 0, 0, "R2");
        step(1, 0, 77, 1, 77, 0, 0, 0, "R2");
        send_quad(0, 0, 0, 33, 44, 222, 66, 1, "R2");
        send_quad(1, 0, 0, 128, 16, 128, 16, 1, "R2");
    endtask

    task automatic t_sleep;
        send_quad(0, 0, 0, 90, 91, 92, 93, 1, "R1");
        step(0, 1, 99, 0, 0, 0, 0, 0, "R1");
        chk(y_out == 0 && cb_out == 0 && cr_out == 0, "R1", "data after sleep",
            int'(y_out) + int'(cb_out) + int'(cr_out), 0);
        send_quad(0, 0, 0, 20, 30, 40, 50, 0, "R1");
        send_quad(1, 0, 0, 20, 30, 40, 50, 0, "R10");
        send_quad(0, 0, 0, 150, 160, 170, 180, 1, "R1");
        send_quad(1, 0, 0, 128, 16, 128, 16, 1, "R9");
    endtask

    initial begin
        t_reset();
        t_presync();
        t_default();
        t_swap();
        t_luma_first();
        t_clamp();
        t_realign();
        t_sleep();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule